// File: doc/BRIEF.md
# Atomic Context Save Sequencer

This block sits inside a crypto engine and, on command, streams the engine's secret state out as an ordered series of 128-bit blocks. Software arms it through a control register that holds a one-way enable and lock, then writes the save code to the operation register. The sequencer walks a fixed layout and pulls each block from one of several stub source ports. The layout is one random block, two sticky-bit blocks, a 64-block key table, 64 RSA-key blocks, optional random filler and a closing known-pattern block. Each block is offered on a valid/ready port together with its block index. For every block the sequencer names the source segment and the offset within it, so an external store can supply the data.

A block-progress counter lives in the control register. It counts accepted blocks and only reset clears it, so each reset allows one save. Completion raises a write-one-to-clear done flag. A save command given while the sequencer is disabled, or while the counter is nonzero, is refused and recorded in the error register. An abort command stops a running save and leaves the counter at its partial value.

The control logic is a two-state machine. `IDLE` goes to `STREAM` on the transition *launch*: a save command with the enable set and the counter at zero. `STREAM` goes back to `IDLE` on the transition *finish*, when the last block is accepted, or on the transition *abort*, when an abort command is written. Every other input leaves the state unchanged.

Top module: `ctxsave_seq`

## Requirements
- R1: After reset, every register reads 0 and `blk_valid` is low. The registers are operation 0x00, status 0x04, interrupt 0x08, error 0x0C and control 0x10.
- R2: The control register holds enable at bit 0, lock at bit 8 and the progress count at bits 25:16. While lock is 0, a write sets enable and lock. While lock is 1, every write to the register is ignored until reset.
- R3: The operation code is in bits 2:0 of a write to the operation register. Only code 3 launches a save. Codes 1, 2 and 4 have no effect, and code 0 has no effect while idle.
- R4: For block index k with TOTAL = 133, `src_sel`/`src_idx` give the source. k=0 gives 0/0 (random). k=1..2 gives 1/k-1 (sticky). k=3..66 gives 2/k-3 (key table). k=67..130 gives 3/k-67 (RSA). k=TOTAL-1 gives 4/0 (known pattern). In the last case `blk_data` is the word 32'h5AC33CA5 repeated four times; otherwise it is the selected source word.
- R5: Within the key table, offset j belongs to slot j/4. The part j%4 is 0 or 1 for the two key blocks, 2 for the original IV and 3 for the updated IV, so each slot is emitted in that order.
- R6: The blocks k=131..TOTAL-2 are random filler with `src_sel`=0 and `src_idx`=k-130. There are TOTAL-132 of them, one at the default.
- R7: The status register bits 1:0 read 1 from the edge that accepts the launch until the edge that accepts the last block, and 0 otherwise. `blk_valid` is high throughout `STREAM`.
- R8: The progress counter rises by one for each block accepted (valid and ready). During a stall, the index and data are held. After a full save, the counter equals TOTAL.
- R9: Interrupt bit 4 is set when the last block is accepted. Writing 1 to bit 4 clears it, and writing 0 leaves it set.
- R10: Error bit 0 records a save command given while the enable is 0. Error bit 1 records a save command given while the counter is nonzero or while a save is running. A refused command emits no block and leaves the counter unchanged.
- R11: An abort (code 0) during `STREAM` drops `blk_valid` in the cycle of the write, returns the sequencer to `IDLE`, keeps the partial count and sets error bit 2.
- R12: The error register reads 0 after a save that completes with no refused or aborted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| blk_valid | output | 1 | A save block is offered |
| blk_ready | input | 1 | The consumer accepts the offered block |
| blk_data | output | BLK_W | Block payload |
| blk_index | output | CNT_W | Position of the block in the save |
| src_sel | output | 3 | Source segment of the current block |
| src_idx | output | CNT_W | Offset of the current block within its segment |
| rnd_word | input | BLK_W | Random-data source word |
| sticky_word | input | BLK_W | Sticky-bit source word |
| key_word | input | BLK_W | Key-table source word |
| rsa_word | input | BLK_W | RSA-key source word |

## Verification
Two complete saves are driven: one with the consumer always ready, and one with the consumer stalling every third cycle. Every block of both saves is compared with a layout computed from the segment sizes. The steady stream shows that each index maps to the right source. The stalled stream shows that the index, data and counter hold still whenever ready is low. The command sequences cover:
- a launch while disabled;
- each operation code that is not the save code;
- a relaunch after completion;
- a relaunch after an abort.

These separate the disabled, already-used and aborted error causes. A write to the control register after lock is set shows that the enable is frozen.

// File: rtl/ctxsave_pkg.sv
package ctxsave_pkg;

    typedef enum logic [2:0] {
        OP_ABORT      = 3'd0,
        OP_START      = 3'd1,
        OP_RESTART    = 3'd2,
        OP_SAVE       = 3'd3,
        OP_RESTART_IN = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        SEG_RND    = 3'd0,
        SEG_STICKY = 3'd1,
        SEG_KEY    = 3'd2,
        SEG_RSA    = 3'd3,
        SEG_PAT    = 3'd4
    } seg_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } st_e;

    localparam logic [7:0] OFS_OP   = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_INT  = 8'h08;
    localparam logic [7:0] OFS_ERR  = 8'h0C;
    localparam logic [7:0] OFS_AUTO = 8'h10;

    localparam int DONE_BIT = 4;
    localparam int LOCK_BIT = 8;
    localparam int CNT_LSB  = 16;

endpackage

// File: rtl/ctxsave_layout.sv
module ctxsave_layout
    import ctxsave_pkg::*;
#(
    parameter int KEY_SLOTS  = 16,
    parameter int RSA_BLKS   = 64,
    parameter int TOTAL_BLKS = 133,
    parameter int CNT_W      = 10
) (
    input  logic [CNT_W-1:0] blk_n,
    output seg_e             seg,
    output logic [CNT_W-1:0] seg_idx,
    output logic             is_last
);
    localparam int KEY_BLKS = KEY_SLOTS * 4;
    localparam logic [CNT_W-1:0] B_STK  = CNT_W'(1);
    localparam logic [CNT_W-1:0] B_KEY  = CNT_W'(3);
    localparam logic [CNT_W-1:0] B_RSA  = CNT_W'(3 + KEY_BLKS);
    localparam logic [CNT_W-1:0] B_FILL = CNT_W'(3 + KEY_BLKS + RSA_BLKS);
    localparam logic [CNT_W-1:0] B_PAT  = CNT_W'(TOTAL_BLKS - 1);

    always_comb begin
        seg     = SEG_PAT;
        seg_idx = '0;
        if (blk_n < B_STK) begin
            seg = SEG_RND;
        end else if (blk_n < B_KEY) begin
            seg     = SEG_STICKY;
            seg_idx = blk_n - B_STK;
        end else if (blk_n < B_RSA) begin
            seg     = SEG_KEY;
            seg_idx = blk_n - B_KEY;
        end else if (blk_n < B_FILL) begin
            seg     = SEG_RSA;
            seg_idx = blk_n - B_RSA;
        end else if (blk_n < B_PAT) begin
            seg     = SEG_RND;
            seg_idx = blk_n - B_FILL + CNT_W'(1);
        end
    end

    assign is_last = (blk_n == B_PAT);

endmodule

// File: rtl/ctxsave_regs.sv
module ctxsave_regs
    import ctxsave_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  logic             done_set,
    input  logic [2:0]       err_set,
    output logic             op_wr,
    output op_e              op_code,
    output logic             auto_en,
    output logic             auto_lock,
    output logic             done_flag
);
    logic [2:0] err_q;
    logic       wr_auto, wr_int;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:9], reg_wdata[7:5], reg_wdata[3]};
    assign op_wr   = reg_we && (reg_addr == OFS_OP[ADDR_W-1:0]);
    assign wr_auto = reg_we && (reg_addr == OFS_AUTO[ADDR_W-1:0]);
    assign wr_int  = reg_we && (reg_addr == OFS_INT[ADDR_W-1:0]);
    assign op_code = op_e'(reg_wdata[2:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_en   <= 1'b0;
            auto_lock <= 1'b0;
            done_flag <= 1'b0;
            err_q     <= '0;
        end else begin
            if (wr_auto && !auto_lock) begin
                auto_en   <= reg_wdata[0];
                auto_lock <= reg_wdata[LOCK_BIT];
            end
            if (done_set)
                done_flag <= 1'b1;
            else if (wr_int && reg_wdata[DONE_BIT])
                done_flag <= 1'b0;
            err_q <= err_q | err_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STAT[ADDR_W-1:0]: reg_rdata[1:0] = {1'b0, busy};
            OFS_INT[ADDR_W-1:0]:  reg_rdata[DONE_BIT] = done_flag;
            OFS_ERR[ADDR_W-1:0]:  reg_rdata[2:0] = err_q;
            OFS_AUTO[ADDR_W-1:0]: begin
                reg_rdata[0]                = auto_en;
                reg_rdata[LOCK_BIT]         = auto_lock;
                reg_rdata[CNT_LSB +: CNT_W] = cnt;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ctxsave_fsm.sv
module ctxsave_fsm
    import ctxsave_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_wr,
    input  op_e              op_code,
    input  logic             auto_en,
    input  logic             is_last,
    input  logic             blk_ready,
    output logic             busy,
    output logic             blk_valid,
    output logic [CNT_W-1:0] cnt,
    output logic             done_set,
    output logic [2:0]       err_set
);
    st_e  state_q, state_d;
    logic save_cmd, abort_cmd, fire;

    assign save_cmd  = op_wr && (op_code == OP_SAVE);
    assign abort_cmd = op_wr && (op_code == OP_ABORT);
    assign blk_valid = (state_q == ST_STREAM) && !abort_cmd;
    assign fire      = blk_valid && blk_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (fire && cnt != '1)  cnt <= cnt + CNT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (save_cmd && auto_en && cnt == '0) state_d = ST_STREAM;
            ST_STREAM: if (abort_cmd || (fire && is_last))    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        done_set = 1'b0;
        err_set  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (save_cmd) begin
                    err_set[0] = !auto_en;
                    err_set[1] = (cnt != '0);
                end
            end
            ST_STREAM: begin
                busy       = 1'b1;
                done_set   = fire && is_last;
                err_set[1] = save_cmd;
                err_set[2] = abort_cmd;
            end
        endcase
    end

endmodule

// File: rtl/ctxsave_seq.sv
module ctxsave_seq
    import ctxsave_pkg::*;
#(
    parameter int              KEY_SLOTS  = 16,
    parameter int              RSA_BLKS   = 64,
    parameter int              TOTAL_BLKS = 133,
    parameter int              CNT_W      = 10,
    parameter int              ADDR_W     = 5,
    parameter int              BLK_W      = 128,
    parameter logic [BLK_W-1:0] KNOWN_PAT = {(BLK_W/32){32'h5AC3_3CA5}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             blk_valid,
    input  logic             blk_ready,
    output logic [BLK_W-1:0] blk_data,
    output logic [CNT_W-1:0] blk_index,
    output logic [2:0]       src_sel,
    output logic [CNT_W-1:0] src_idx,
    input  logic [BLK_W-1:0] rnd_word,
    input  logic [BLK_W-1:0] sticky_word,
    input  logic [BLK_W-1:0] key_word,
    input  logic [BLK_W-1:0] rsa_word
);
    logic             busy_w, op_wr_w, auto_en_w, auto_lock_w, done_w;
    logic             done_set_w, is_last_w;
    logic [2:0]       err_set_w;
    logic [CNT_W-1:0] cnt_w;
    op_e              op_code_w;
    seg_e             seg_w;

    ctxsave_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w),
        .cnt(cnt_w), .done_set(done_set_w), .err_set(err_set_w),
        .op_wr(op_wr_w), .op_code(op_code_w), .auto_en(auto_en_w),
        .auto_lock(auto_lock_w), .done_flag(done_w)
    );

    ctxsave_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr_w), .op_code(op_code_w),
        .auto_en(auto_en_w), .is_last(is_last_w), .blk_ready(blk_ready),
        .busy(busy_w), .blk_valid(blk_valid), .cnt(cnt_w),
        .done_set(done_set_w), .err_set(err_set_w)
    );

    ctxsave_layout #(
        .KEY_SLOTS(KEY_SLOTS), .RSA_BLKS(RSA_BLKS),
        .TOTAL_BLKS(TOTAL_BLKS), .CNT_W(CNT_W)
    ) layout_i (
        .blk_n(cnt_w), .seg(seg_w), .seg_idx(src_idx), .is_last(is_last_w)
    );

    assign blk_index = cnt_w;
    assign src_sel   = seg_w;

    always_comb begin
        unique case (seg_w)
            SEG_RND:    blk_data = rnd_word;
            SEG_STICKY: blk_data = sticky_word;
            SEG_KEY:    blk_data = key_word;
            SEG_RSA:    blk_data = rsa_word;
            default:    blk_data = KNOWN_PAT;
        endcase
    end

endmodule

// File: rtl/ctxsave_chk.sv
module ctxsave_chk #(
    parameter int TOTAL_BLKS = 133,
    parameter int CNT_W      = 10,
    parameter int ADDR_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2:0]       op_bits,
    input logic             blk_valid,
    input logic             blk_ready,
    input logic [CNT_W-1:0] blk_index,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             auto_en,
    input logic             auto_lock,
    input logic             done_bit
);
    logic abort_wr;
    assign abort_wr = reg_we && (reg_addr == '0) && (op_bits == 3'd0);

    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        auto_lock |=> auto_lock && $stable(auto_en));

    p_index_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (blk_index < CNT_W'(TOTAL_BLKS)));

    p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> busy);

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_valid && blk_ready) |=> $stable(cnt));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_done_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_bit) |-> (cnt == CNT_W'(TOTAL_BLKS)));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_wr && busy) |=> !busy);

endmodule

bind ctxsave_seq ctxsave_chk #(
    .TOTAL_BLKS(TOTAL_BLKS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .op_bits(reg_wdata[2:0]), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_index(blk_index), .busy(busy_w), .cnt(cnt_w), .auto_en(auto_en_w),
    .auto_lock(auto_lock_w), .done_bit(done_w)
);

// File: tb/ctxsave_seq_tb_top.sv
module ctxsave_seq_tb_top;
    localparam int TOTAL = 133;
    localparam int CW    = 10;
    localparam int AW    = 5;
    localparam logic [127:0] PAT = {4{32'h5AC3_3CA5}};
    localparam logic [AW-1:0] A_OP = 5'h00, A_ST = 5'h04, A_INT = 5'h08,
                              A_ERR = 5'h0C, A_AUTO = 5'h10;

    logic          clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, blk_ready = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0, reg_rdata;
    logic          blk_valid;
    logic [127:0]  blk_data, rnd_word, sticky_word, key_word, rsa_word;
    logic [CW-1:0] blk_index, src_idx;
    logic [2:0]    src_sel;
    int            errors = 0, checks = 0;

    always #10 clk = ~clk;

    function automatic logic [127:0] mk(input int sel, input int idx);
        return {8'(sel), 24'hC0FFEE, 32'(idx), 32'(idx * 7 + sel), 32'hA5A5_0000 ^ 32'(sel)};
    endfunction

    assign rnd_word    = mk(0, int'(src_idx));
    assign sticky_word = mk(1, int'(src_idx));
    assign key_word    = mk(2, int'(src_idx));
    assign rsa_word    = mk(3, int'(src_idx));

    ctxsave_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_valid(blk_valid),
        .blk_ready(blk_ready), .blk_data(blk_data), .blk_index(blk_index),
        .src_sel(src_sel), .src_idx(src_idx), .rnd_word(rnd_word),
        .sticky_word(sticky_word), .key_word(key_word), .rsa_word(rsa_word)
    );

    function automatic int e_sel(input int k);
        if (k == 0)          return 0;
        if (k < 3)           return 1;
        if (k < 67)          return 2;
        if (k < 131)         return 3;
        if (k < TOTAL - 1)   return 0;
        return 4;
    endfunction

    function automatic int e_idx(input int k);
        if (k == 0)          return 0;
        if (k < 3)           return k - 1;
        if (k < 67)          return k - 3;
        if (k < 131)         return k - 67;
        if (k < TOTAL - 1)   return k - 130;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_we = 1'b0; blk_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic stream_all(input int stall_mod);
        int k = 0;
        int guard = 0;
        reg_addr = A_ST;
        while (k < TOTAL && guard < 1000) begin
            bit rdy;
            int es, ei;
            logic [127:0] ed;
            #1;
            es = e_sel(k);
            ei = e_idx(k);
            ed = (es == 4) ? PAT : mk(es, ei);
            rdy = (stall_mod == 0) ? 1'b1 : ((guard % stall_mod) != 1);
            chk(blk_valid == 1'b1, "R7 valid during save", blk_valid, 1);
            chk(reg_rdata[1:0] == 2'd1, "R7 status busy", reg_rdata[1:0], 1);
            chk(int'(blk_index) == k, "R8 block index/hold", blk_index, k);
            chk(int'(src_sel) == es, "R4 segment select", src_sel, es);
            chk(int'(src_idx) == ei, (es == 2) ? "R5 key slot/part" : (k > 130 && es == 0) ? "R6 filler index" : "R4 segment offset", src_idx, ei);
            chk(blk_data == ed, "R4 block data", blk_data, ed);
            blk_ready = rdy;
            @(negedge clk);
            if (rdy) k++;
            guard++;
        end
        blk_ready = 1'b0;
        #1;
        chk(blk_valid == 1'b0, "R7 valid low after last", blk_valid, 0);
        chk(reg_rdata[1:0] == 2'd0, "R7 status idle after last", reg_rdata[1:0], 0);
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rd_chk(A_OP, 0, "R1 op reset");
        rd_chk(A_ST, 0, "R1 status reset");
        rd_chk(A_INT, 0, "R1 int reset");
        rd_chk(A_ERR, 0, "R1 err reset");
        rd_chk(A_AUTO, 0, "R1 ctrl reset");
        chk(blk_valid == 1'b0, "R1 valid reset", blk_valid, 0);

        // R10 launch while disabled
        wr(A_OP, 32'd3);
        #1; chk(blk_valid == 1'b0, "R10 no block when disabled", blk_valid, 0);
        rd_chk(A_ST, 0, "R10 status idle when disabled");
        rd_chk(A_ERR, 32'h1, "R10 err disabled bit");
        rd_chk(A_AUTO, 0, "R10 count untouched");

        // R2 enable and lock
        do_reset();
        wr(A_AUTO, 32'h1);   rd_chk(A_AUTO, 32'h1, "R2 enable unlocked");
        wr(A_AUTO, 32'h0);   rd_chk(A_AUTO, 32'h0, "R2 unlocked change");
        wr(A_AUTO, 32'h101); rd_chk(A_AUTO, 32'h101, "R2 enable+lock");
        wr(A_AUTO, 32'h0);   rd_chk(A_AUTO, 32'h101, "R2 locked write ignored");

        // R3 other codes do nothing
        for (int c = 0; c < 5; c++) begin
            if (c == 3) continue;
            wr(A_OP, 32'(c));
            #1; chk(blk_valid == 1'b0, "R3 no launch for code", blk_valid, 0);
            rd_chk(A_ST, 0, "R3 status idle for code");
        end
        rd_chk(A_ERR, 0, "R3 err clear after other codes");

        // Full save with a stall every third cycle
        wr(A_OP, 32'd3);
        stream_all(3);
        rd_chk(A_INT, 32'h10, "R9 done set");
        rd_chk(A_ERR, 0, "R12 err clean after save");
        rd_chk(A_AUTO, (32'(TOTAL) << 16) | 32'h101, "R8 count equals total");
        wr(A_INT, 32'h0);  rd_chk(A_INT, 32'h10, "R9 write 0 keeps done");
        wr(A_INT, 32'h10); rd_chk(A_INT, 32'h0, "R9 write 1 clears done");

        // R10 relaunch after completion
        wr(A_OP, 32'd3);
        #1; chk(blk_valid == 1'b0, "R10 relaunch no block", blk_valid, 0);
        rd_chk(A_ERR, 32'h2, "R10 err counter nonzero");
        rd_chk(A_AUTO, (32'(TOTAL) << 16) | 32'h101, "R10 count unchanged");

        // Full save with steady ready
        do_reset();
        wr(A_AUTO, 32'h101);
        wr(A_OP, 32'd3);
        stream_all(0);
        rd_chk(A_ERR, 0, "R12 err clean steady save");
        rd_chk(A_INT, 32'h10, "R9 done after steady save");

        // R11 abort mid-save
        do_reset();
        wr(A_AUTO, 32'h101);
        wr(A_OP, 32'd3);
        blk_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            #1; chk(int'(blk_index) == i, "R8 index before abort", blk_index, i);
            @(negedge clk);
        end
        reg_we = 1'b1; reg_addr = A_OP; reg_wdata = 32'd0;
        #1; chk(blk_valid == 1'b0, "R11 valid low during abort", blk_valid, 0);
        @(negedge clk);
        reg_we = 1'b0; blk_ready = 1'b0;
        rd_chk(A_ST, 0, "R11 idle after abort");
        rd_chk(A_AUTO, (32'd10 << 16) | 32'h101, "R11 partial count kept");
        rd_chk(A_ERR, 32'h4, "R11 abort err bit");
        rd_chk(A_INT, 0, "R11 no done on abort");
        wr(A_OP, 32'd3);
        #1; chk(blk_valid == 1'b0, "R10 relaunch after abort", blk_valid, 0);
        rd_chk(A_ERR, 32'h6, "R10 err after abort relaunch");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule